// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. A host writes a byte into a single holding register. When the shift engine is free, the byte moves into the engine and is sent as a start bit, five to eight data bits, an optional parity bit and a stop period. The pacing comes from an external oversampling enable. Every bit lasts sixteen of those enable pulses.

A 7-bit control word sets the frame shape. It selects the word length, the stop length and the parity scheme, which can be odd, even, forced high or forced low. It also carries a break request that holds the line low. The engine captures the shape when each frame starts. Two flags tell the host when the holding register can take another byte and when the transmitter has gone fully quiet.

Top module: `sertx_core`

## Requirements
- R1: Out of reset, and whenever nothing is queued, the line rests at 1 and both status flags read 1.
- R2: A frame opens with one start bit of 0. The data bits follow, least significant first. Control bits [1:0] give the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: Control bit 2 sets the stop period, which is always at 1. With bit 2 clear the period is 16 ticks. With bit 2 set it is 24 ticks for 5-bit words and 32 ticks for longer words.
- R4: Control bit 3 adds a parity bit between the last data bit and the stop period. With bit 5 clear, bit 4 set gives even parity and bit 4 clear gives odd parity, both taken over the data bits that are sent.
- R5: With bits 3 and 5 both set, the parity bit is the inverse of bit 4. A control value of 0x28 sends a 1 and 0x38 sends a 0.
- R6: While control bit 6 is set, the line is 0 at once, the character being sent is abandoned and nothing new starts. After bit 6 clears, a byte held in the meantime starts a fresh frame on the next clock.
- R7: The holding-empty flag drops on the clock that accepts a write. It rises on the clock that moves the byte into an idle shift engine, even though shifting then continues.
- R8: The transmitter-empty flag is 1 only when the holding register is empty and the shift engine is idle. It rises on the clock after the last stop tick.
- R9: A write while the holding register is full is ignored, and the held byte is sent unchanged.
- R10: A byte that is waiting starts on the final stop tick of the previous frame, with no idle gap between the two frames.
- R11: The frame shape is captured at the start of each frame. Changes to control bits 0 to 5 during a frame affect only later frames.
- R12: The engine advances only on clocks where the tick input is high, so each bit spans 16 ticks at any tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| lcr_i | input | 7 | Frame control word (length, stop, parity, break) |
| wr_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Byte to send |
| tx_o | output | 1 | Serial line |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| tx_empty_o | output | 1 | Holding register and shift engine both idle |

## Verification
Take E0 as the edge that accepts a write. The start bit appears one clock after E0, because the holding register adds one stage. With one tick per clock, bit j is centred 8 + 16·j clocks later, and the bench samples each bit at that centre. Both flags fall at E0. The holding-empty flag rises again one clock later. The transmitter-empty flag rises exactly L + 1 clocks after E0, where L is 16 times the number of start, data and parity bits plus the stop ticks. The bench checks that flag at both L and L + 1 to pin down the stop length. Break takes effect combinationally and is sampled right after it is changed. With a slower tick, only bit centres are checked, since each bit boundary then moves by less than one tick period.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int LCR_W = 7;
  // control word bit positions (word length in [1:0])
  localparam int B_STOP  = 2;
  localparam int B_PEN   = 3;
  localparam int B_PSEL  = 4;
  localparam int B_STICK = 5;
  localparam int B_BRK   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  function automatic logic par_bit(input logic [LCR_W-1:0] lcr, input logic [7:0] d);
    logic [7:0] dm;
    dm = d & (8'hFF >> (2'd3 - lcr[1:0]));
    if (lcr[B_STICK]) return ~lcr[B_PSEL];
    return lcr[B_PSEL] ? ^dm : ~^dm;
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i && !full_q) begin
        full_q <= 1'b1;
        data_q <= wdata_i;
      end else if (pop_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i && !pop_i) |=> $stable(data_q)); // R9
  AST_POP_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> full_q); // R7
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             brk_i,
  input  logic [5:0]       fmt_i,
  input  logic             avail_i,
  input  logic [7:0]       data_i,
  output logic             pop_o,
  output logic             line_o,
  output logic             busy_o
);
  localparam int CW = $clog2(2*OSR + 1);
  localparam logic [CW-1:0] BIT_END = CW'(OSR - 1);
  localparam logic [CW-1:0] STOP_1  = CW'(OSR);
  localparam logic [CW-1:0] STOP_15 = CW'(OSR + OSR/2);
  localparam logic [CW-1:0] STOP_2  = CW'(2*OSR);

  tx_state_e     st_q;
  logic [CW-1:0] cnt_q, stop_q, end_cnt;
  logic [3:0]    bit_q, nbits_q;
  logic [7:0]    sh_q;
  logic          par_en_q, par_q, bit_end;

  assign end_cnt = (st_q == ST_STOP) ? stop_q - 1'b1 : BIT_END;
  assign bit_end = tick_i && (cnt_q == end_cnt);
  assign pop_o   = avail_i && !brk_i &&
                   ((st_q == ST_IDLE) || (st_q == ST_STOP && bit_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      stop_q   <= STOP_1;
      bit_q    <= '0;
      nbits_q  <= 4'd8;
      sh_q     <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (brk_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (pop_o) begin
      st_q     <= ST_START;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= data_i;
      nbits_q  <= 4'd5 + {2'b00, fmt_i[1:0]};
      par_en_q <= fmt_i[B_PEN];
      par_q    <= par_bit({1'b0, fmt_i}, data_i);
      if (!fmt_i[B_STOP])        stop_q <= STOP_1;
      else if (fmt_i[1:0] == 2'd0) stop_q <= STOP_15;
      else                       stop_q <= STOP_2;
    end else if (tick_i && st_q != ST_IDLE) begin
      if (bit_end) begin
        cnt_q <= '0;
        unique case (st_q)
          ST_START: st_q <= ST_DATA;
          ST_DATA: begin
            sh_q  <= sh_q >> 1;
            bit_q <= bit_q + 1'b1;
            if (bit_q == nbits_q - 1'b1) st_q <= par_en_q ? ST_PAR : ST_STOP;
          end
          ST_PAR:  st_q <= ST_STOP;
          default: st_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  AST_BREAK_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> (st_q == ST_IDLE)); // R6
  AST_LOAD_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (st_q == ST_START && !line_o)); // R2
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !brk_i && !pop_o) |=> ($stable(st_q) && $stable(cnt_q))); // R12
  AST_CNT_IN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (cnt_q <= end_cnt)); // R3
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LCR_W-1:0] lcr_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic             tx_o,
  output logic             hold_empty_o,
  output logic             tx_empty_o
);
  logic       full, pop, line, busy, brk;
  logic [7:0] hdata;

  assign brk = lcr_i[B_BRK];

  sertx_hold #(.DW(8)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .pop_i   (pop),
    .full_o  (full),
    .data_o  (hdata)
  );

  sertx_shift #(.OSR(OSR)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .brk_i   (brk),
    .fmt_i   (lcr_i[5:0]),
    .avail_i (full),
    .data_i  (hdata),
    .pop_o   (pop),
    .line_o  (line),
    .busy_o  (busy)
  );

  // break overrides the frame immediately
  assign tx_o         = brk ? 1'b0 : line;
  assign hold_empty_o = !full;
  assign tx_empty_o   = !full && !busy;

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o); // R8
  AST_POP_FREES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !wr_i) |=> hold_empty_o); // R7
endmodule

// File: tb/sertx_core_test.sv
module sertx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] lcr = 7'h03;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       tx, hold_empty, tx_empty;
  int         n_run = 0, n_fail = 0, tper = 1, tdiv = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tper == 0) tick = 1'b0;
    else begin
      tick = (tdiv == 0);
      tdiv = (tdiv >= tper - 1) ? 0 : tdiv + 1;
    end
  end

  sertx_core uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .lcr_i(lcr),
    .wr_i(wr), .wdata_i(wdata), .tx_o(tx),
    .hold_empty_o(hold_empty), .tx_empty_o(tx_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [6:0] lc, input logic [7:0] d);
    logic [7:0] dm;
    dm = d & (8'hFF >> (3 - lc[1:0]));
    if (lc[5]) return ~lc[4];
    return lc[4] ? ^dm : ~^dm;
  endfunction

  task automatic put(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // entered 'off' negedges after the one following the load edge
  // mode 0: idle end with exact flag timing, 1: back-to-back, 2: slow tick
  task automatic frame(input logic [6:0] lc, input logic [7:0] d, input int tp,
                       input int mode, input int off);
    int n, p, st, k;
    n  = 5 + int'(lc[1:0]);
    p  = int'(lc[3]);
    st = !lc[2] ? 16 : (lc[1:0] == 0 ? 24 : 32);
    k  = 1 + n + p;
    repeat (8*tp - off) @(negedge clk);
    check("R2 start bit", tx, 0);
    for (int i = 0; i < n; i++) begin
      repeat (16*tp) @(negedge clk);
      check("R2 data bit", tx, d[i]);
    end
    if (p != 0) begin
      repeat (16*tp) @(negedge clk);
      check(lc[5] ? "R5 stick parity" : "R4 parity", tx, exp_par(lc, d));
    end
    repeat (16*tp) @(negedge clk);
    check("R3 stop level", tx, 1);
    if (mode == 0) begin
      repeat (st - 9) @(negedge clk);
      check("R3 stop length not early", tx_empty, 0);
      check("R3 stop level end", tx, 1);
      @(negedge clk);
      check("R8 tx empty rise", tx_empty, 1);
      check("R1 idle flag", hold_empty, 1);
    end else if (mode == 1) begin
      repeat (st - 8) @(negedge clk);
      check("R10 no gap start", tx, 0);
    end else begin
      repeat (st*tp) @(negedge clk);
      check("R12 slow tick end", tx_empty, 1);
    end
    if (k < 0) $display("unreachable");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] pm [5];
    pm[0] = 7'h00; pm[1] = 7'h08; pm[2] = 7'h18; pm[3] = 7'h28; pm[4] = 7'h38;
    repeat (3) @(negedge clk);
    check("R1 reset line", tx, 1);
    check("R1 reset hold empty", hold_empty, 1);
    check("R1 reset tx empty", tx_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle line", tx, 1);

    // sweep all word lengths, stop settings and parity modes
    for (int wl = 0; wl < 4; wl++)
      for (int sb = 0; sb < 2; sb++)
        for (int m = 0; m < 5; m++) begin
          logic [7:0] d;
          d = 8'h5A ^ 8'((wl*10 + sb*5 + m) * 37);
          lcr = pm[m] | 7'(sb << 2) | 7'(wl);
          put(d);
          check("R7 hold empty falls", hold_empty, 0);
          check("R8 tx empty falls", tx_empty, 0);
          @(negedge clk);
          check("R7 hold empty while shifting", hold_empty, 1);
          frame(lcr, d, 1, 0, 0);
        end

    // overflow, back-to-back and format capture
    lcr = 7'h03;
    put(8'hC3);
    @(negedge clk);
    lcr = 7'h00;                     // R11: applies only to the next frame
    put(8'h16);
    check("R7 hold full after second write", hold_empty, 0);
    put(8'hFF);                      // R9: must be dropped
    frame(7'h03, 8'hC3, 1, 1, 2);
    frame(7'h00, 8'h16, 1, 0, 0);    // R9 R10 R11

    // break
    lcr = 7'h03;
    put(8'hA5);
    repeat (40) @(negedge clk);
    lcr = 7'h43;
    #1 check("R6 break immediate", tx, 0);
    @(negedge clk);
    put(8'h3C);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R6 break holds low", tx, 0);
    end
    check("R6 byte kept during break", hold_empty, 0);
    check("R8 not empty during break", tx_empty, 0);
    lcr = 7'h03;
    #1 check("R6 old char dropped", tx, 1);
    @(negedge clk);
    frame(7'h03, 8'h3C, 1, 0, 0);

    // slower tick rate
    tper = 3;
    @(negedge clk);
    lcr = 7'h1B;
    put(8'h96);
    @(negedge clk);
    frame(7'h1B, 8'h96, 3, 2, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule